// File: doc/BRIEF.md
# Windowed Subsampling Readout Sequencer

This block drives the addressing of a pixel array that is read one row at a time. It selects a row, strobes that selection, and then moves a column address across the part of the row that is being read. It emits a pixel-valid pulse for each address. Line and frame markers let the downstream converter and packer find row and frame boundaries without counting.

Three scan shapes are available. The whole array can be read in raster order. A rectangular region of interest can be read instead; it is clipped at the array edge. Both axes can also be strided by a programmable factor. Region and stride can be used together, so moving the origin pans and tilts the picture and changing the stride zooms it. The configuration is captured only when a frame is launched, so software may rewrite it at any time without harming the frame in flight. Pixels advance only in cycles where the pixel-rate enable is high.

Top module: `rdseq_top`

## Requirements
- R1: After reset the block is idle: row_sel, pix_valid, line_end and frame_end are low until a start pulse is accepted.
- R2: With windowing and skipping both off, a frame visits every row 0..ROWS-1 in ascending order and, within each row, every column 0..COLS-1 in ascending order.
- R3: With windowing on, rows run from win_row up to but excluding min(win_row+win_h, ROWS), and columns run from win_col up to but excluding min(win_col+win_w, COLS).
- R4: With skipping on, the stride is skip_n, and any skip_n value of 0 or 1 is treated as 2. The stride applies to both rows and columns, counted from the region origin. The last address on each axis is the largest origin+k*stride that lies below the region end.
- R5: Windowing and skipping combine: the visited set is the clipped region of R3 sampled with the stride of R4, for every combination of origin, size and stride.
- R6: The mode, region and stride inputs are sampled only in the cycle a start is accepted, which is only possible when idle. Changing them, or pulsing start, while a frame runs has no effect on that frame.
- R7: Each row is announced by a single-cycle row_sel, during which row_addr already shows the new row. The row_sel cycle comes one cycle before that row's first pixel cycle. row_sel and pix_valid are never high together, and row_addr holds for the whole row.
- R8: pix_valid is high for exactly one cycle per addressed pixel and only in cycles where pix_en is high. In cycles where pix_en is low, the column address does not advance.
- R9: line_end is high together with pix_valid on the last column of every row, and at no other time.
- R10: frame_end is high with the last pixel of the frame. An empty region (zero size, or origin at or past the array edge on either axis) gives a single frame_end cycle, one cycle after start, with no row_sel and no pix_valid. The block is idle in the cycle after any frame_end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a frame; honoured only when idle |
| pix_en | input | 1 | Pixel-rate enable; one pixel may be read per high cycle |
| win_en | input | 1 | 1 = read the region of interest, 0 = whole array |
| skip_en | input | 1 | 1 = stride rows and columns by the skip factor |
| skip_n | input | SKW | Skip factor (values below 2 act as 2) |
| win_col | input | CAW | Region origin column |
| win_row | input | RAW | Region origin row |
| win_w | input | CAW+1 | Region width in columns |
| win_h | input | RAW+1 | Region height in rows |
| row_addr | output | RAW | Selected row address |
| row_sel | output | 1 | One-cycle strobe announcing a new selected row |
| col_addr | output | CAW | Column address of the current pixel |
| pix_valid | output | 1 | Current column address is being read this cycle |
| line_end | output | 1 | Last pixel of the current row |
| frame_end | output | 1 | Last pixel of the frame, or empty-frame marker |

## Verification
The two events that fall in the same cycle are the end of a row and the end of the frame: on the final pixel, line_end and frame_end rise together with pix_valid. This case is provoked by sweeping origin, size and stride so that the last row and the last column land on every possible offset from the clipped edge, including one-pixel and one-row regions. The bench computes the expected final address from the clipped end and the stride, and requires both markers on exactly that pixel and neither marker earlier. A second collision is tested in the same sweep: a start pulse and rewritten configuration are driven while the frame runs, and the bench requires the frame to continue unchanged.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EMPTY  = 2'd1,
        ST_ROWSEL = 2'd2,
        ST_PIXEL  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic frame_init;
        logic row_step;
        logic col_rewind;
        logic col_step;
    } step_cmd_t;

    // Effective stride: 1 when skipping is off, never below 2 when on.
    function automatic int stride_of(input logic skip_on, input int n);
        if (!skip_on) return 1;
        return (n < 2) ? 2 : n;
    endfunction

    // Exclusive end of a region on one axis, clipped to the array bound.
    function automatic int clip_end(input int org, input int size, input int lim);
        return (org + size > lim) ? lim : org + size;
    endfunction

endpackage

// File: rtl/rdseq_axis_cfg.sv
module rdseq_axis_cfg
    import rdseq_pkg::*;
#(
    parameter int LIM = 16,
    parameter int AW  = $clog2(LIM)
) (
    input  logic          win_on,
    input  logic [AW-1:0] org_in,
    input  logic [AW:0]   size_in,
    output logic [AW-1:0] org_o,
    output logic [AW:0]   end_o,
    output logic          empty_o
);
    localparam int EW = AW + 1;

    always_comb begin
        if (win_on) begin
            org_o = org_in;
            end_o = EW'(clip_end(int'(org_in), int'(size_in), LIM));
        end else begin
            org_o = '0;
            end_o = EW'(LIM);
        end
        empty_o = (EW'(org_o) >= end_o);
    end

endmodule

// File: rtl/rdseq_axis_step.sv
module rdseq_axis_step #(
    parameter int AW  = 4,
    parameter int SKW = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           init,
    input  logic           rewind,
    input  logic           step,
    input  logic [AW-1:0]  org_in,
    input  logic [AW:0]    end_in,
    input  logic [SKW-1:0] stride_in,
    output logic [AW-1:0]  pos_o,
    output logic           last_o
);
    localparam int NW = ((AW > SKW) ? AW : SKW) + 1;

    logic [AW-1:0]  org_q;
    logic [AW:0]    end_q;
    logic [SKW-1:0] stride_q;
    logic [AW-1:0]  pos_q;
    logic [NW-1:0]  nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            org_q    <= '0;
            end_q    <= '0;
            stride_q <= '0;
            pos_q    <= '0;
        end else if (init) begin
            org_q    <= org_in;
            end_q    <= end_in;
            stride_q <= stride_in;
            pos_q    <= org_in;
        end else if (rewind) begin
            pos_q <= org_q;
        end else if (step) begin
            pos_q <= AW'(nxt);
        end
    end

    assign nxt    = NW'(pos_q) + NW'(stride_q);
    assign last_o = (nxt >= NW'(end_q));
    assign pos_o  = pos_q;

endmodule

// File: rtl/rdseq_ctrl.sv
module rdseq_ctrl
    import rdseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       pix_en,
    input  logic       cfg_empty,
    input  logic       col_last,
    input  logic       row_last,
    output seq_state_e state_o,
    output step_cmd_t  cmd_o
);
    seq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        cmd_o   = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    cmd_o.frame_init = 1'b1;
                    state_d = cfg_empty ? ST_EMPTY : ST_ROWSEL;
                end
            end
            ST_EMPTY:  state_d = ST_IDLE;
            ST_ROWSEL: state_d = ST_PIXEL;
            ST_PIXEL: begin
                if (pix_en) begin
                    if (!col_last) begin
                        cmd_o.col_step = 1'b1;
                    end else if (row_last) begin
                        state_d = ST_IDLE;
                    end else begin
                        cmd_o.row_step   = 1'b1;
                        cmd_o.col_rewind = 1'b1;
                        state_d = ST_ROWSEL;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/rdseq_top.sv
module rdseq_top
    import rdseq_pkg::*;
#(
    parameter  int COLS = 16,
    parameter  int ROWS = 12,
    parameter  int SKW  = 3,
    localparam int CAW  = $clog2(COLS),
    localparam int RAW  = $clog2(ROWS)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           pix_en,
    input  logic           win_en,
    input  logic           skip_en,
    input  logic [SKW-1:0] skip_n,
    input  logic [CAW-1:0] win_col,
    input  logic [RAW-1:0] win_row,
    input  logic [CAW:0]   win_w,
    input  logic [RAW:0]   win_h,
    output logic [RAW-1:0] row_addr,
    output logic           row_sel,
    output logic [CAW-1:0] col_addr,
    output logic           pix_valid,
    output logic           line_end,
    output logic           frame_end
);
    logic [CAW-1:0] c_org;
    logic [CAW:0]   c_end;
    logic           c_empty;
    logic [RAW-1:0] r_org;
    logic [RAW:0]   r_end;
    logic           r_empty;
    logic [SKW-1:0] stride;
    logic           col_last, row_last;
    seq_state_e     state;
    step_cmd_t      cmd;

    assign stride = SKW'(stride_of(skip_en, int'(skip_n)));

    rdseq_axis_cfg #(.LIM(COLS), .AW(CAW)) u_col_cfg (
        .win_on (win_en),
        .org_in (win_col),
        .size_in(win_w),
        .org_o  (c_org),
        .end_o  (c_end),
        .empty_o(c_empty)
    );

    rdseq_axis_cfg #(.LIM(ROWS), .AW(RAW)) u_row_cfg (
        .win_on (win_en),
        .org_in (win_row),
        .size_in(win_h),
        .org_o  (r_org),
        .end_o  (r_end),
        .empty_o(r_empty)
    );

    rdseq_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .pix_en   (pix_en),
        .cfg_empty(c_empty | r_empty),
        .col_last (col_last),
        .row_last (row_last),
        .state_o  (state),
        .cmd_o    (cmd)
    );

    rdseq_axis_step #(.AW(CAW), .SKW(SKW)) u_col_step (
        .clk      (clk),
        .rst      (rst),
        .init     (cmd.frame_init),
        .rewind   (cmd.col_rewind),
        .step     (cmd.col_step),
        .org_in   (c_org),
        .end_in   (c_end),
        .stride_in(stride),
        .pos_o    (col_addr),
        .last_o   (col_last)
    );

    rdseq_axis_step #(.AW(RAW), .SKW(SKW)) u_row_step (
        .clk      (clk),
        .rst      (rst),
        .init     (cmd.frame_init),
        .rewind   (1'b0),
        .step     (cmd.row_step),
        .org_in   (r_org),
        .end_in   (r_end),
        .stride_in(stride),
        .pos_o    (row_addr),
        .last_o   (row_last)
    );

    assign row_sel   = (state == ST_ROWSEL);
    assign pix_valid = (state == ST_PIXEL) && pix_en;
    assign line_end  = pix_valid && col_last;
    assign frame_end = (line_end && row_last) || (state == ST_EMPTY);

endmodule

// File: rtl/rdseq_chk.sv
module rdseq_chk #(
    parameter int RAW = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           pix_en,
    input logic           row_sel,
    input logic           pix_valid,
    input logic           line_end,
    input logic           frame_end,
    input logic [RAW-1:0] row_addr
);
    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!pix_valid && !row_sel && !frame_end));

    assert_valid_needs_enable_R8: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> pix_en);

    assert_rowsel_single_R7: assert property (@(posedge clk) disable iff (rst)
        row_sel |=> !row_sel);

    assert_rowsel_excl_valid_R7: assert property (@(posedge clk) disable iff (rst)
        !(row_sel && pix_valid));

    assert_row_held_R7: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && !line_end) |=> $stable(row_addr));

    assert_line_end_on_pixel_R9: assert property (@(posedge clk) disable iff (rst)
        line_end |-> pix_valid);

    assert_frame_end_closes_row_R10: assert property (@(posedge clk) disable iff (rst)
        (frame_end && pix_valid) |-> line_end);

    assert_idle_after_frame_R10: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (!pix_valid && !row_sel && !frame_end));

endmodule

bind rdseq_top rdseq_chk #(.RAW(RAW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .pix_en   (pix_en),
    .row_sel  (row_sel),
    .pix_valid(pix_valid),
    .line_end (line_end),
    .frame_end(frame_end),
    .row_addr (row_addr)
);

// File: tb/rdseq_top_tb.sv
`timescale 1ns/1ps
module rdseq_top_tb;
    localparam int NC  = 7;
    localparam int NR  = 5;
    localparam int SKW = 3;
    localparam int CAW = 3;
    localparam int RAW = 3;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic           pix_en = 1'b0;
    logic           win_en = 1'b0;
    logic           skip_en = 1'b0;
    logic [SKW-1:0] skip_n = '0;
    logic [CAW-1:0] win_col = '0;
    logic [RAW-1:0] win_row = '0;
    logic [CAW:0]   win_w = '0;
    logic [RAW:0]   win_h = '0;
    logic [RAW-1:0] row_addr;
    logic           row_sel;
    logic [CAW-1:0] col_addr;
    logic           pix_valid;
    logic           line_end;
    logic           frame_end;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #10 clk = ~clk;

    rdseq_top #(.COLS(NC), .ROWS(NR), .SKW(SKW)) u_dut (
        .clk(clk), .rst(rst), .start(start), .pix_en(pix_en),
        .win_en(win_en), .skip_en(skip_en), .skip_n(skip_n),
        .win_col(win_col), .win_row(win_row), .win_w(win_w), .win_h(win_h),
        .row_addr(row_addr), .row_sel(row_sel), .col_addr(col_addr),
        .pix_valid(pix_valid), .line_end(line_end), .frame_end(frame_end)
    );

    task automatic chk(input int act, input int exp, input string tag, input string what);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic run_frame(input bit we, input bit se, input int sn,
                             input int c0, input int w, input int r0, input int h,
                             input string tag);
        int s, co, ce, ro, re;
        bit empty, pe;
        s  = !se ? 1 : ((sn < 2) ? 2 : sn);
        co = we ? c0 : 0;
        ro = we ? r0 : 0;
        ce = we ? ((c0 + w > NC) ? NC : c0 + w) : NC;
        re = we ? ((r0 + h > NR) ? NR : r0 + h) : NR;
        empty = (co >= ce) || (ro >= re);

        @(negedge clk);
        win_en = we; skip_en = se; skip_n = SKW'(sn);
        win_col = CAW'(c0); win_w = (CAW+1)'(w);
        win_row = RAW'(r0); win_h = (RAW+1)'(h);
        pix_en = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // rewrite configuration while the frame runs (R6)
        win_en = ~win_en; skip_en = ~skip_en; skip_n = skip_n + 1'b1;
        win_col = ~win_col; win_w = ~win_w; win_row = ~win_row; win_h = ~win_h;
        if (empty) begin
            pix_en = 1'b1; #1;
            chk(frame_end, 1, "R10", "empty frame marker");
            chk(pix_valid, 0, "R10", "empty frame valid");
            chk(row_sel, 0, "R10", "empty frame row_sel");
        end else begin
            for (int r = ro; r < re; r += s) begin
                if (r != ro) @(negedge clk);
                pix_en = 1'b1; start = 1'b0; #1;
                chk(row_sel, 1, "R7", "row strobe");
                chk(int'(row_addr), r, tag, "row address at strobe");
                chk(pix_valid, 0, "R7", "valid during strobe");
                for (int c = co; c < ce; ) begin
                    @(negedge clk);
                    pe = (((cyc * 5) + 1) % 7) < 5;
                    cyc++;
                    pix_en = pe;
                    start = (c == co && r != ro);   // ignored mid-frame (R6)
                    #1;
                    if (pe) begin
                        chk(pix_valid, 1, "R8", "valid with enable");
                        chk(int'(col_addr), c, tag, "column address");
                        chk(int'(row_addr), r, tag, "row address");
                        chk(row_sel, 0, "R7", "no strobe mid-row");
                        chk(line_end, (c + s >= ce) ? 1 : 0, "R9", "line end");
                        chk(frame_end, (c + s >= ce && r + s >= re) ? 1 : 0, "R10", "frame end");
                        c += s;
                    end else begin
                        chk(pix_valid, 0, "R8", "valid without enable");
                        chk(line_end, 0, "R9", "line end without enable");
                        chk(int'(col_addr), c, "R8", "column held");
                    end
                end
            end
        end
        start = 1'b0;
        @(negedge clk);
        pix_en = 1'b1; #1;
        chk(pix_valid, 0, "R10", "idle after frame valid");
        chk(row_sel, 0, "R10", "idle after frame row_sel");
        chk(frame_end, 0, "R10", "idle after frame marker");
        pix_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R8 watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0; pix_en = 1'b1; start = 1'b0; #1;
        chk(pix_valid, 0, "R1", "reset valid");
        chk(row_sel, 0, "R1", "reset row_sel");
        chk(frame_end, 0, "R1", "reset frame_end");
        chk(line_end, 0, "R1", "reset line_end");
        @(negedge clk); #1;
        chk(pix_valid, 0, "R1", "idle valid");

        run_frame(0, 0, 0, 3, 2, 1, 1, "R2");
        run_frame(1, 0, 0, 4, 6, 3, 5, "R3");
        run_frame(1, 0, 0, 1, 3, 2, 2, "R3");
        run_frame(0, 1, 3, 0, 0, 0, 0, "R4");
        run_frame(0, 1, 0, 0, 0, 0, 0, "R4");
        run_frame(0, 1, 1, 0, 0, 0, 0, "R4");
        run_frame(1, 1, 2, 1, 5, 1, 4, "R5");
        run_frame(1, 0, 0, 2, 0, 1, 3, "R10");
        run_frame(1, 1, 3, 7, 3, 0, 2, "R10");
        run_frame(1, 0, 0, 6, 1, 4, 1, "R10");

        for (int c0 = 0; c0 < 8; c0++) begin
            for (int w = 0; w < 9; w++) begin
                for (int m = 0; m < 4; m++) begin
                    run_frame(m[0], m[1], (c0 + 2 * w + m) % 8,
                              c0, w, (c0 + w) % 6, (w * 3 + c0) % 7, "R5");
                end
            end
        end

        summary();
        $finish;
    end

endmodule